// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This peripheral guards a system against software that stops running. A 10-bit down-counter is clocked by a tick-enable strobe, which an external prescaler pulses once per timer tick. Each tick stands for 0.6 s of real time. When the count runs out for the first time, the block only records the event in a timeout flag and can interrupt the processor. The counter then reloads and starts a second period. If software has not cleared the flag by the time that second period ends, the block records a second-timeout flag and sends a one-cycle pulse to the system reset logic. A board-level veto input can block this pulse.

Software controls the block through a small 16-bit register port. The port has a byte offset, write data, a write strobe and combinational read data. Through it, software can:
- restart the period by writing any value to the count register;
- program the initial value, where values below 4 are refused;
- stop or run the counter with a halt bit;
- read the live count;
- clear the sticky status flags by writing ones to them.

The tick prescaler, the system reset sequencing and any configuration-space access are not part of this block.

Top module: `dsw_watchdog`

## Requirements
- R1: After reset the halt bit is 1, the initial value is 4, the live count is 4, every status flag is 0, and `sys_rst` and `irq` are low. While halted, ticks leave the count unchanged.
- R2: Offset 0x00 reads the live count in bits 9:0, with bits 15:10 reading 0. While the halt bit (offset 0x08, bit 11) is 0, each `tick` lowers the count by one. While the halt bit is 1, the count holds.
- R3: A write of any value to offset 0x00 loads the count from bits 9:0 of the initial-value register.
- R4: Offset 0x12 holds the initial value in bits 9:0 and keeps bits 15:10 as written, and all 16 bits read back as stored. A write whose bits 9:0 are 0 to 3 is discarded as a whole. A value of exactly 4 is accepted.
- R5: A `tick` that finds the count at 0 is an expiry, so a period lasts initial-value + 1 ticks. An expiry reloads the count from the initial value. If the timeout flag (offset 0x04, bit 3) is 0, the expiry sets it.
- R6: An expiry while the timeout flag is already 1 sets the second-timeout flag (offset 0x06, bit 1). It also drives `sys_rst` high for exactly one clock cycle, starting at the clock edge that takes the expiring tick.
- R7: The status flags are write-one-to-clear: writing 1 clears a flag, and writing 0 leaves it unchanged. Clearing the timeout flag between expiries means a further first expiry is needed before any reset.
- R8: While `reset_veto` is high at an expiry that would reset, `sys_rst` stays low and the boot flag is left unchanged, but the second-timeout flag is still set.
- R9: The boot flag (offset 0x06, bit 2) is set whenever a reset pulse is issued, and is cleared by writing 1 to it.
- R10: `irq` is high exactly while the timeout flag is 1 and `irq_en` is high.
- R11: Of the control register at offset 0x08 only bit 11 is stored. All its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe per timer tick |
| addr | input | 5 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| reset_veto | input | 1 | High blocks the reset pulse |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| sys_rst | output | 1 | One-cycle system reset request |

## Verification
The main function is tried with four tick patterns, each telling apart a different kind of fault:
- Uninterrupted expiry pairs show whether the reset falls on exactly the second expiry rather than the first, and whether each period is the initial value plus one tick.
- Clearing the timeout flag between expiries shows whether the escalation restarts instead of remembering the earlier expiry.
- Ticks given while halted show whether the halt bit really stops the count.
- Expiry pairs with the veto held show whether the reset is blocked while the second-timeout flag is still recorded.

Boundary writes to the initial-value register (3 and 4) tell the refusal threshold apart from off-by-one errors. Writes of zero to status flags tell the write-one-to-clear decoding apart from a plain write.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

    // register byte offsets seen by software
    localparam int unsigned OFS_COUNT = 'h00;
    localparam int unsigned OFS_STAT1 = 'h04;
    localparam int unsigned OFS_STAT2 = 'h06;
    localparam int unsigned OFS_CTRL  = 'h08;
    localparam int unsigned OFS_INIT  = 'h12;

    // bit positions that software decodes
    localparam int unsigned HALT_BIT   = 11;
    localparam int unsigned TOUT_BIT   = 3;
    localparam int unsigned SECOND_BIT = 1;
    localparam int unsigned BOOT_BIT   = 2;

    // escalation state shared between the escalation stage and the top
    typedef struct packed {
        logic tout;
        logic second;
        logic boot;
        logic rst_pulse;
    } esc_state_t;

endpackage

// File: rtl/dsw_counter.sv
module dsw_counter #(
    parameter int unsigned CNT_W   = 10,
    parameter int unsigned RST_VAL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             reload,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       run;

    always_comb begin
        s_d    = s_q;
        run    = tick && !halt;
        expire = run && (s_q.cnt == '0) && !reload;
        if (reload || expire) begin
            s_d.cnt = init_val;
        end else if (run) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= CNT_W'(RST_VAL);
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> $stable(s_q.cnt));

    // R3
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (s_q.cnt == $past(init_val)));

    // R5
    expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (s_q.cnt == $past(init_val)));

endmodule

// File: rtl/dsw_escalate.sv
module dsw_escalate
    import dsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire,
    input  logic       veto,
    input  logic       clr_tout,
    input  logic       clr_second,
    input  logic       clr_boot,
    output esc_state_t st
);

    esc_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.rst_pulse = 1'b0;
        if (clr_tout)   st_d.tout   = 1'b0;
        if (clr_second) st_d.second = 1'b0;
        if (clr_boot)   st_d.boot   = 1'b0;
        if (expire) begin
            if (st_q.tout) begin
                st_d.second = 1'b1;
                if (!veto) begin
                    st_d.rst_pulse = 1'b1;
                    st_d.boot      = 1'b1;
                end
            end else begin
                st_d.tout = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_pulse |=> !st_q.rst_pulse);

    // R6
    second_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.second) |-> $past(st_q.tout));

    // R8
    veto_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        veto |=> !st_q.rst_pulse);

    // R9
    pulse_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_pulse |-> (st_q.second && st_q.boot));

endmodule

// File: rtl/dsw_regs.sv
module dsw_regs
    import dsw_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned INIT_MIN = 4,
    parameter int unsigned INIT_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              tout_sts,
    input  logic              second_sts,
    input  logic              boot_sts,
    output logic [DATA_W-1:0] rdata,
    output logic              halt,
    output logic [CNT_W-1:0]  init_val,
    output logic              reload,
    output logic              clr_tout,
    output logic              clr_second,
    output logic              clr_boot
);

    typedef struct packed {
        logic              halt;
        logic [DATA_W-1:0] init;
    } regs_t;

    regs_t r_d, r_q;
    logic  sel_count, sel_stat1, sel_stat2, sel_ctrl, sel_init;
    logic  init_ok;

    always_comb begin
        sel_count = (addr == ADDR_W'(OFS_COUNT));
        sel_stat1 = (addr == ADDR_W'(OFS_STAT1));
        sel_stat2 = (addr == ADDR_W'(OFS_STAT2));
        sel_ctrl  = (addr == ADDR_W'(OFS_CTRL));
        sel_init  = (addr == ADDR_W'(OFS_INIT));
        init_ok   = (wdata[CNT_W-1:0] >= CNT_W'(INIT_MIN));

        r_d = r_q;
        if (wr_en && sel_ctrl) begin
            r_d.halt = wdata[HALT_BIT];
        end
        if (wr_en && sel_init && init_ok) begin
            r_d.init = wdata;
        end

        reload     = wr_en && sel_count;
        clr_tout   = wr_en && sel_stat1 && wdata[TOUT_BIT];
        clr_second = wr_en && sel_stat2 && wdata[SECOND_BIT];
        clr_boot   = wr_en && sel_stat2 && wdata[BOOT_BIT];

        rdata = '0;
        if (sel_count) begin
            rdata[CNT_W-1:0] = cnt;
        end else if (sel_stat1) begin
            rdata[TOUT_BIT] = tout_sts;
        end else if (sel_stat2) begin
            rdata[SECOND_BIT] = second_sts;
            rdata[BOOT_BIT]   = boot_sts;
        end else if (sel_ctrl) begin
            rdata[HALT_BIT] = r_q.halt;
        end else if (sel_init) begin
            rdata = r_q.init;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.halt <= 1'b1;
            r_q.init <= DATA_W'(INIT_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign halt     = r_q.halt;
    assign init_val = r_q.init[CNT_W-1:0];

    // R4
    init_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.init[CNT_W-1:0] >= CNT_W'(INIT_MIN));

    // R4
    low_init_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_init && (wdata[CNT_W-1:0] < CNT_W'(INIT_MIN))) |=> $stable(r_q.init));

endmodule

// File: rtl/dsw_watchdog.sv
module dsw_watchdog
    import dsw_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned INIT_MIN = 4,
    parameter int unsigned INIT_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              reset_veto,
    input  logic              irq_en,
    output logic              irq,
    output logic              sys_rst
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] init_val;
    logic             halt, reload, expire;
    logic             clr_tout, clr_second, clr_boot;
    esc_state_t       st;

    dsw_regs #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .INIT_MIN(INIT_MIN),
        .INIT_RST(INIT_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .cnt       (cnt),
        .tout_sts  (st.tout),
        .second_sts(st.second),
        .boot_sts  (st.boot),
        .rdata     (rdata),
        .halt      (halt),
        .init_val  (init_val),
        .reload    (reload),
        .clr_tout  (clr_tout),
        .clr_second(clr_second),
        .clr_boot  (clr_boot)
    );

    dsw_counter #(
        .CNT_W  (CNT_W),
        .RST_VAL(INIT_RST)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .halt    (halt),
        .reload  (reload),
        .init_val(init_val),
        .cnt     (cnt),
        .expire  (expire)
    );

    dsw_escalate u_escalate (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .veto      (reset_veto),
        .clr_tout  (clr_tout),
        .clr_second(clr_second),
        .clr_boot  (clr_boot),
        .st        (st)
    );

    assign irq     = st.tout && irq_en;
    assign sys_rst = st.rst_pulse;

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_tout) |=> (st.tout || !irq_en));

endmodule

// File: tb/dsw_watchdog_tb.sv
module dsw_watchdog_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        reset_veto = 1'b0;
    logic        irq_en = 1'b0;
    logic        irq;
    logic        sys_rst;

    int n_checks = 0;
    int n_fails  = 0;
    logic rst_seen;
    logic rst_any;

    always #5 clk = ~clk;

    dsw_watchdog u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .addr      (addr),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .rdata     (rdata),
        .reset_veto(reset_veto),
        .irq_en    (irq_en),
        .irq       (irq),
        .sys_rst   (sys_rst)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        rst_seen = sys_rst;
        rst_any  = rst_any | sys_rst;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 sys_rst", {15'd0, sys_rst}, 16'd0);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        rd(5'h00, v); chk("R1 count", v, 16'h0004);
        rd(5'h08, v); chk("R1 halt", v, 16'h0800);
        rd(5'h12, v); chk("R1 init", v, 16'h0004);
        rd(5'h04, v); chk("R1 stat1", v, 16'h0000);
        rd(5'h06, v); chk("R1 stat2", v, 16'h0000);
        do_tick(); do_tick();
        rd(5'h00, v); chk("R1 halted count", v, 16'h0004);
    endtask

    task automatic t_count();
        logic [15:0] v;
        wr(5'h08, 16'hF7FF);
        rd(5'h08, v); chk("R11 ctrl other bits", v, 16'h0000);
        wr(5'h12, 16'hA40A);
        rd(5'h12, v); chk("R4 init readback", v, 16'hA40A);
        wr(5'h00, 16'h0000);
        rd(5'h00, v); chk("R3 reload", v, 16'h000A);
        do_tick(); do_tick(); do_tick();
        rd(5'h00, v); chk("R2 decrement", v, 16'h0007);
        wr(5'h08, 16'h0800);
        rd(5'h08, v); chk("R2 halt readback", v, 16'h0800);
        do_tick(); do_tick();
        rd(5'h00, v); chk("R2 halt holds", v, 16'h0007);
        wr(5'h08, 16'h0000);
        do_tick();
        rd(5'h00, v); chk("R2 resume", v, 16'h0006);
    endtask

    task automatic t_ignore();
        logic [15:0] v;
        wr(5'h12, 16'hFC03);
        rd(5'h12, v); chk("R4 value 3 ignored", v, 16'hA40A);
        wr(5'h12, 16'h0000);
        rd(5'h12, v); chk("R4 value 0 ignored", v, 16'hA40A);
        wr(5'h12, 16'h0004);
        rd(5'h12, v); chk("R4 value 4 accepted", v, 16'h0004);
        wr(5'h00, 16'h1234);
        rd(5'h00, v); chk("R3 reload any data", v, 16'h0004);
    endtask

    task automatic t_first();
        logic [15:0] v;
        wr(5'h12, 16'h0005);
        wr(5'h00, 16'h0000);
        for (int i = 0; i < 5; i++) do_tick();
        rd(5'h00, v); chk("R5 count at zero", v, 16'h0000);
        rd(5'h04, v); chk("R5 no flag before expiry", v, 16'h0000);
        do_tick();
        chk("R5 no reset on first", {15'd0, rst_seen}, 16'd0);
        rd(5'h04, v); chk("R5 flag set", v, 16'h0008);
        rd(5'h00, v); chk("R5 reloaded", v, 16'h0005);
        irq_en = 1'b1; #1;
        chk("R10 irq enabled", {15'd0, irq}, 16'd1);
        irq_en = 1'b0; #1;
        chk("R10 irq masked", {15'd0, irq}, 16'd0);
        irq_en = 1'b1;
    endtask

    task automatic t_second();
        logic [15:0] v;
        rst_any = 1'b0;
        for (int i = 0; i < 5; i++) do_tick();
        chk("R6 no early reset", {15'd0, rst_any}, 16'd0);
        do_tick();
        chk("R6 reset pulse", {15'd0, rst_seen}, 16'd1);
        @(negedge clk);
        chk("R6 pulse one cycle", {15'd0, sys_rst}, 16'd0);
        rd(5'h06, v); chk("R9 stat2 second+boot", v, 16'h0006);
        rd(5'h04, v); chk("R6 stat1 still set", v, 16'h0008);
    endtask

    task automatic t_w1c();
        logic [15:0] v;
        wr(5'h04, 16'hFFF7);
        rd(5'h04, v); chk("R7 zero write keeps", v, 16'h0008);
        wr(5'h04, 16'h0008);
        rd(5'h04, v); chk("R7 clear tout", v, 16'h0000);
        chk("R10 irq drops", {15'd0, irq}, 16'd0);
        wr(5'h06, 16'h0002);
        rd(5'h06, v); chk("R9 boot remains", v, 16'h0004);
        wr(5'h06, 16'h0004);
        rd(5'h06, v); chk("R9 boot cleared", v, 16'h0000);
    endtask

    task automatic t_clear_between();
        logic [15:0] v;
        rst_any = 1'b0;
        wr(5'h00, 16'h0000);
        for (int i = 0; i < 6; i++) do_tick();
        wr(5'h04, 16'h0008);
        for (int i = 0; i < 6; i++) do_tick();
        chk("R7 no reset after clear", {15'd0, rst_any}, 16'd0);
        rd(5'h04, v); chk("R7 first again", v, 16'h0008);
        rd(5'h06, v); chk("R7 no second", v, 16'h0000);
        for (int i = 0; i < 6; i++) do_tick();
        chk("R7 reset after two more", {15'd0, rst_seen}, 16'd1);
        wr(5'h04, 16'h0008);
        wr(5'h06, 16'h0006);
    endtask

    task automatic t_veto();
        logic [15:0] v;
        rst_any = 1'b0;
        reset_veto = 1'b1;
        wr(5'h00, 16'h0000);
        for (int i = 0; i < 12; i++) do_tick();
        chk("R8 veto blocks reset", {15'd0, rst_any}, 16'd0);
        rd(5'h06, v); chk("R8 second only", v, 16'h0002);
        reset_veto = 1'b0;
        wr(5'h06, 16'h0002);
        rd(5'h06, v); chk("R7 clear second", v, 16'h0000);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_any = 1'b0;
        rst_seen = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_ignore();
        t_first();
        t_second();
        t_w1c();
        t_clear_between();
        t_veto();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule